// File: doc/BRIEF.md
# Highest-Priority Match Iterator

This block sits behind the compare stage of an associative lookup array. When a compare finishes, the block takes the per-entry hit vector. It keeps only the hits that fall on entries marked valid and stores the result as a working match set. The lowest-numbered surviving entry is the current match. Its address is shown on `cur_addr` and is also driven on `mem_addr`, the address of the storage read port. `match_found` reports whether any match is left.

A read-next command is recognised when `cmd_valid` is high, `cmd_we` is high (no write) and `cmd_op` equals the read code `000001`. It captures one 32-bit half of the current entry: the low half when `half_sel` is 0 and the high half when it is 1. The block drives that half on `dq_out` with `dq_oe` high for exactly one cycle. The same command removes the entry from the working set, so the next match becomes current. When no match is left, a read leaves `dq_oe` low, which models an undriven bus.

The controller has three states:
- `ST_IDLE`: no match is left.
- `ST_HIT`: a match is pending and the bus is quiet.
- `ST_OUT`: read data is on the bus this cycle.

The transitions are:
- load-hit: a compare with at least one valid hit goes to `ST_HIT`, from any state.
- load-miss: a compare with no valid hit goes to `ST_IDLE`, from any state.
- read-fire: `ST_HIT` or `ST_OUT` goes to `ST_OUT` when a read-next arrives and a match exists.
- drain: `ST_OUT` goes to `ST_HIT` when matches remain, or to `ST_IDLE` when none remain, if no command acts.

Top module: `hpm_iterator`

## Requirements
- R1: After reset, `match_found` is 0 and `dq_oe` is 0.
- R2: One cycle after `cmp_load`, the working set equals `cmp_hits & ent_valid`, so hits on invalid entries never count. `match_found` is 1 exactly when that set is non-empty.
- R3: While `match_found` is 1, `cur_addr` is the lowest index in the working set (the lowest index has the highest priority).
- R4: A read-next command (`cmd_valid`=1, `cmd_we`=1, `cmd_op`=000001) issued while `match_found` is 1 sets `dq_oe` high in the next cycle for one cycle. `dq_out` then carries bits 31:0 of the current entry if `half_sel`=0, or bits 63:32 if `half_sel`=1.
- R5: A read-next removes the current entry from the working set. From the next cycle `cur_addr` shows the next match, and `match_found` drops after the last match has been read.
- R6: A read-next issued while `match_found` is 0 leaves `dq_oe` at 0.
- R7: A command with `cmd_we`=0, or with any opcode other than 000001, has no effect: `dq_oe` stays 0 and `cur_addr` and `match_found` are unchanged.
- R8: When `cmp_load` and a read-next happen in the same cycle, the compare wins. The read is dropped (`dq_oe` stays 0) and the new hit vector is loaded.
- R9: A new compare discards the iteration state left over from earlier reads.
- R10: `mem_addr` always equals `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_load | input | 1 | A compare result is present this cycle |
| cmp_hits | input | ENTRIES | Per-entry hit vector from the compare |
| ent_valid | input | ENTRIES | Per-entry validity bits |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_we | input | 1 | Write-enable level (1 = no write) |
| cmd_op | input | OP_W | Opcode low bits |
| half_sel | input | 1 | 0 selects bits 31:0, 1 selects bits 63:32 |
| mem_addr | output | AW | Storage read-port address |
| mem_rdata | input | ENTRY_W | Storage read-port data (combinational) |
| cur_addr | output | AW | Current highest-priority match address |
| match_found | output | 1 | At least one match is left |
| dq_out | output | ENTRY_W/2 | Read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The compare load and the read-next can arrive in the same cycle. The bench provokes this by first loading a two-hit vector, then issuing a read-next together with a new compare whose only hit is at a different index. The bench judges the result one cycle later:
- `dq_oe` must be low.
- `cur_addr` must name the new compare's hit.
- A following read must return that new entry's data.

Any of these showing the old entry or a driven bus means the read leaked through.

// File: rtl/hpm_iter_pkg.sv
package hpm_iter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_OUT  = 2'd2
    } iter_state_e;

endpackage

// File: rtl/mi_prio_enc.sv
module mi_prio_enc #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [AW-1:0] idx
);

    // Scan from the top down, so the last hit seen is the lowest index.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
        found = |req;
    end

    // R3: the chosen index must point at a set request bit.
    always_comb begin
        if (found === 1'b1) begin
            a_r3_idx_hits: assert (req[idx]);
        end
    end

endmodule

// File: rtl/mi_match_vec.sv
module mi_match_vec #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [N-1:0]  load_hits,
    input  logic [N-1:0]  load_valid,
    input  logic          clr,
    input  logic [AW-1:0] clr_idx,
    output logic [N-1:0]  work
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    work[g] <= 1'b0;
                end else if (load) begin
                    work[g] <= load_hits[g] & load_valid[g];
                end else if (clr && (clr_idx == AW'(g))) begin
                    work[g] <= 1'b0;
                end
            end
        end
    endgenerate

    // R5: a cleared slot is empty in the next cycle.
    a_r5_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> !work[$past(clr_idx)]);

endmodule

// File: rtl/mi_half_mux.sv
module mi_half_mux #(
    parameter int WORD_W = 64,
    parameter int HALF_W = WORD_W / 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic              hi,
    output logic [HALF_W-1:0] half
);

    always_comb begin
        half = hi ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
    end

endmodule

// File: rtl/hpm_iterator.sv
module hpm_iterator
    import hpm_iter_pkg::*;
#(
    parameter int             ENTRIES   = 16,
    parameter int             ENTRY_W   = 64,
    parameter int             OP_W      = 6,
    parameter logic [OP_W-1:0] READ_CODE = OP_W'(1),
    localparam int            AW        = $clog2(ENTRIES),
    localparam int            HALF_W    = ENTRY_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_load,
    input  logic [ENTRIES-1:0] cmp_hits,
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic               cmd_valid,
    input  logic               cmd_we,
    input  logic [OP_W-1:0]    cmd_op,
    input  logic               half_sel,
    output logic [AW-1:0]      mem_addr,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic [AW-1:0]      cur_addr,
    output logic               match_found,
    output logic [HALF_W-1:0]  dq_out,
    output logic               dq_oe
);

    iter_state_e        state, state_nx;
    logic [ENTRIES-1:0] work;
    logic               any_hit;
    logic [AW-1:0]      top_idx;
    logic [HALF_W-1:0]  half_data;
    logic [HALF_W-1:0]  dq_q;
    logic               rd_cmd;
    logic               rd_fire;
    logic               load_any;

    assign rd_cmd   = cmd_valid & cmd_we & (cmd_op == READ_CODE);
    assign rd_fire  = rd_cmd & ~cmp_load & any_hit;
    assign load_any = |(cmp_hits & ent_valid);

    mi_match_vec #(.N(ENTRIES), .AW(AW)) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cmp_load),
        .load_hits  (cmp_hits),
        .load_valid (ent_valid),
        .clr        (rd_fire),
        .clr_idx    (top_idx),
        .work       (work)
    );

    mi_prio_enc #(.N(ENTRIES), .AW(AW)) u_enc (
        .req   (work),
        .found (any_hit),
        .idx   (top_idx)
    );

    mi_half_mux #(.WORD_W(ENTRY_W), .HALF_W(HALF_W)) u_mux (
        .word (mem_rdata),
        .hi   (half_sel),
        .half (half_data)
    );

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmp_load) state_nx = load_any ? ST_HIT : ST_IDLE;
            end
            ST_HIT, ST_OUT: begin
                if (cmp_load)     state_nx = load_any ? ST_HIT : ST_IDLE;
                else if (rd_fire) state_nx = ST_OUT;
                else              state_nx = any_hit ? ST_HIT : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Data capture on a fired read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dq_q <= '0;
        else if (rd_fire) dq_q <= half_data;
    end

    // Outputs.
    always_comb begin
        dq_oe       = (state == ST_OUT);
        dq_out      = dq_oe ? dq_q : '0;
        match_found = any_hit;
        cur_addr    = top_idx;
        mem_addr    = top_idx;
    end

    a_r2_load_found: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_load |=> (match_found == $past(load_any)));

    a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> dq_oe);

    a_r4_drive_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(rd_fire));

    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> (!match_found || (cur_addr != $past(cur_addr))));

    a_r6_no_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !match_found) |=> !dq_oe);

    a_r8_compare_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_load |=> !dq_oe);

    a_r3_hit_state_has_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIT) |-> match_found);

endmodule

// File: tb/hpm_iterator_test.sv
`timescale 1ns/1ps
module hpm_iterator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_load = 1'b0;
    logic [15:0] cmp_hits = '0;
    logic [15:0] ent_valid = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_we = 1'b0;
    logic [5:0]  cmd_op = '0;
    logic        half_sel = 1'b0;
    logic [3:0]  mem_addr;
    logic [63:0] mem_rdata;
    logic [3:0]  cur_addr;
    logic        match_found;
    logic [31:0] dq_out;
    logic        dq_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [63:0] mem_word(input logic [3:0] a);
        return {28'hC3C3C3C, a, 28'h5A5A5A5, ~a};
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    hpm_iterator uut (
        .clk(clk), .rst_n(rst_n), .cmp_load(cmp_load), .cmp_hits(cmp_hits),
        .ent_valid(ent_valid), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
        .cmd_op(cmd_op), .half_sel(half_sel), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .cur_addr(cur_addr), .match_found(match_found),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic cl, input logic [15:0] h, input logic [15:0] v,
                        input logic cv, input logic we, input logic [5:0] op,
                        input logic hs);
        cmp_load = cl; cmp_hits = h; ent_valid = v;
        cmd_valid = cv; cmd_we = we; cmd_op = op; half_sel = hs;
        @(negedge clk);
        cmp_load = 1'b0; cmd_valid = 1'b0; cmd_we = 1'b0; cmd_op = '0;
    endtask

    task automatic load(input logic [15:0] h, input logic [15:0] v);
        step(1'b1, h, v, 1'b0, 1'b0, 6'd0, 1'b0);
    endtask

    task automatic rd(input logic hs);
        step(1'b0, '0, '0, 1'b1, 1'b1, 6'b000001, hs);
    endtask

    function automatic logic [31:0] exp_half(input logic [3:0] a, input logic hs);
        logic [63:0] w;
        w = mem_word(a);
        return hs ? w[63:32] : w[31:0];
    endfunction

    function automatic int lowest(input logic [15:0] s);
        for (int i = 0; i < 16; i++) if (s[i]) return i;
        return -1;
    endfunction

    localparam int NV = 5;
    localparam logic [15:0] V_HITS  [NV] = '{16'h00F0, 16'h8001, 16'hFFFF, 16'h8000, 16'hA5A5};
    localparam logic [15:0] V_VALID [NV] = '{16'hFFFF, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0FF0};
    localparam logic        V_HALF  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int          V_FIRST [NV] = '{4, 0, 0, 15, 5};
    localparam int          V_CNT   [NV] = '{4, 1, 0, 1, 4};

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] rem;
        int reads;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 match_found at reset", match_found, 0);
        chk("R1 dq_oe at reset", dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            load(V_HITS[v], V_VALID[v]);
            rem = V_HITS[v] & V_VALID[v];
            chk("R2 match_found after load", match_found, V_CNT[v] != 0);
            if (V_CNT[v] != 0) chk("R3 first address", cur_addr, V_FIRST[v]);
            reads = 0;
            for (int k = 0; k < 17; k++) begin
                if (rem == 0) break;
                chk("R3 current is lowest", cur_addr, lowest(rem));
                chk("R10 mem_addr follows", mem_addr, cur_addr);
                rd(V_HALF[v]);
                chk("R4 dq_oe after read", dq_oe, 1);
                chk("R4 dq_out half", dq_out, exp_half(4'(lowest(rem)), V_HALF[v]));
                rem[lowest(rem)] = 1'b0;
                reads++;
                chk("R5 match_found tracks remaining", match_found, rem != 0);
            end
            chk("R5 read count", reads, V_CNT[v]);
            rd(V_HALF[v]);
            chk("R6 no drive when exhausted", dq_oe, 0);
        end

        // R7 ignored commands
        load(16'h0014, 16'hFFFF);
        step(1'b0, '0, '0, 1'b1, 1'b0, 6'b000001, 1'b0);
        chk("R7 we low no drive", dq_oe, 0);
        chk("R7 we low addr kept", cur_addr, 2);
        step(1'b0, '0, '0, 1'b1, 1'b1, 6'b000010, 1'b0);
        chk("R7 other op no drive", dq_oe, 0);
        chk("R7 other op addr kept", cur_addr, 2);
        chk("R7 other op match kept", match_found, 1);

        // R8 compare and read together
        load(16'h0006, 16'hFFFF);
        step(1'b1, 16'h0100, 16'hFFFF, 1'b1, 1'b1, 6'b000001, 1'b1);
        chk("R8 read dropped", dq_oe, 0);
        chk("R8 new vector current", cur_addr, 8);
        rd(1'b1);
        chk("R8 next read new entry", dq_out, exp_half(4'd8, 1'b1));
        chk("R8 vector drained", match_found, 0);

        // R9 new compare discards iteration
        load(16'h0003, 16'hFFFF);
        rd(1'b0);
        chk("R9 advanced", cur_addr, 1);
        load(16'h0005, 16'hFFFF);
        chk("R9 restart at lowest", cur_addr, 0);
        rd(1'b0);
        rd(1'b0);
        chk("R9 second entry of new set", dq_out, exp_half(4'd2, 1'b0));
        @(negedge clk);
        chk("R4 drive lasts one cycle", dq_oe, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule